// File: doc/BRIEF.md
# Single-Precision Floating-Point Adder/Subtractor

This block adds or subtracts two 32-bit binary floating-point numbers and returns a 32-bit result one clock cycle later. Each operand packs a sign, a biased exponent and a fraction whose leading one is implied. When neither operand is zero, the block restores the hidden one on both operands. It then orders the operands by magnitude and shifts the smaller significand right to line it up with the larger exponent. Next it adds or subtracts the two magnitudes and moves the leading one back to the hidden position.

Subtraction flips the sign of the second operand before any other work. After that the block only works with magnitudes. Results are truncated, never rounded. An exponent field of zero counts as a zero operand, so denormal inputs are flushed. Results that leave the normal range are either saturated to infinity or flushed to +0.

Top module: `fpadd_top`

## Requirements
- R1: Field layout of operands and result: the sign is bit 31, the exponent (excess-127) is bits 30:23, and the fraction is bits 22:0. A normal value carries an implied leading one above bit 22.
- R2: The result is registered and appears one clock after the operands are presented. While reset is low the result is held at 32'h0000_0000.
- R3: When `sub_sel` is 1 the block computes `opnd_a - opnd_b` by inverting the sign of `opnd_b`. When it is 0 the block computes `opnd_a + opnd_b`.
- R4: An operand whose exponent field is zero is a zero operand. If `opnd_a` is zero, the result is `opnd_b` with its sign inverted when subtracting. Otherwise, if `opnd_b` is zero, the result is `opnd_a` unchanged.
- R5: The operand of smaller magnitude has its significand shifted right by the exponent difference. Shifted-out bits are discarded, and the larger exponent becomes the working exponent.
- R6: When the effective signs match, the significands are added. A carry out of the hidden position shifts the sum right by one, dropping its lowest bit, and increments the exponent.
- R7: When the effective signs differ, the smaller magnitude is subtracted from the larger, and the result takes the sign of the larger-magnitude operand.
- R8: After a subtraction, the difference is shifted left by its leading-zero count, and the exponent is reduced by that same count.
- R9: A difference of exactly zero produces +0 (32'h0000_0000).
- R10: If the exponent after a carry would reach all ones, the result is infinity with the sign of the result (exponent 8'hFF, fraction 0).
- R11: If the exponent after normalization would be zero or negative, the result is flushed to +0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| opnd_a | input | 32 | First operand |
| opnd_b | input | 32 | Second operand |
| sub_sel | input | 1 | 0 selects add, 1 selects subtract |
| result | output | 32 | Registered sum or difference |

## Verification
The bench builds the block with its default widths: an 8-bit exponent and a 23-bit fraction. With these widths the hand-computed vectors map directly onto single-precision encodings. They also put the edge cases within reach: the largest finite exponent, for the saturation to infinity, and exponent one, for the flush to zero. A 24-bit significand lets one-ulp differences drive the leading-zero count to its deepest value, 23. It also lets an exponent gap of 30 push the aligned operand fully out of range.

// File: rtl/fpadd_pkg.sv
package fpadd_pkg;
  localparam int DEF_EXP_W  = 8;
  localparam int DEF_FRAC_W = 23;

  typedef enum logic {
    OP_ADD = 1'b0,
    OP_SUB = 1'b1
  } fp_op_e;
endpackage

// File: rtl/fpadd_align.sv
module fpadd_align #(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23
) (
  input  logic [EXP_W+FRAC_W:0] a_word,
  input  logic [EXP_W+FRAC_W:0] b_word,
  input  logic                  b_sign_eff,
  output logic                  a_zero,
  output logic                  b_zero,
  output logic                  big_sign,
  output logic [EXP_W-1:0]      big_exp,
  output logic [FRAC_W:0]       big_sig,
  output logic [FRAC_W:0]       small_sig_al,
  output logic                  eff_sub
);
  localparam int W     = 1 + EXP_W + FRAC_W;
  localparam int SIG_W = FRAC_W + 1;

  logic [EXP_W-1:0] exp_a, exp_b, small_exp, exp_gap;
  logic [SIG_W-1:0] sig_a, sig_b, small_sig;
  logic             a_is_big;

  assign exp_a  = a_word[W-2:FRAC_W];
  assign exp_b  = b_word[W-2:FRAC_W];
  assign a_zero = (exp_a == '0);
  assign b_zero = (exp_b == '0);
  assign sig_a  = {1'b1, a_word[FRAC_W-1:0]};
  assign sig_b  = {1'b1, b_word[FRAC_W-1:0]};

  // exponent sits above fraction, so the low W-1 bits order by magnitude
  assign a_is_big  = (a_word[W-2:0] >= b_word[W-2:0]);
  assign big_exp   = a_is_big ? exp_a : exp_b;
  assign small_exp = a_is_big ? exp_b : exp_a;
  assign big_sig   = a_is_big ? sig_a : sig_b;
  assign small_sig = a_is_big ? sig_b : sig_a;
  assign big_sign  = a_is_big ? a_word[W-1] : b_sign_eff;
  assign eff_sub   = a_word[W-1] ^ b_sign_eff;
  assign exp_gap   = big_exp - small_exp;

  always_comb begin
    if (exp_gap >= EXP_W'(SIG_W)) small_sig_al = '0;
    else                           small_sig_al = small_sig >> exp_gap;
  end

  always_comb begin
    assert_order_R5: assert (big_exp >= small_exp)
      else $error("alignment picked the smaller exponent");
  end
endmodule

// File: rtl/fpadd_magadd.sv
module fpadd_magadd #(
  parameter int FRAC_W = 23
) (
  input  logic [FRAC_W:0]   big_sig,
  input  logic [FRAC_W:0]   small_sig,
  input  logic              eff_sub,
  output logic [FRAC_W+1:0] raw_sum,
  output logic              carry_out,
  output logic              exact_zero
);
  localparam int SIG_W = FRAC_W + 1;

  always_comb begin
    if (eff_sub) raw_sum = {1'b0, big_sig} - {1'b0, small_sig};
    else         raw_sum = {1'b0, big_sig} + {1'b0, small_sig};
  end

  assign carry_out  = !eff_sub && raw_sum[SIG_W];
  assign exact_zero = (raw_sum == '0);

  always_comb begin
    if (eff_sub)
      assert_no_borrow_R7: assert (raw_sum[SIG_W] == 1'b0)
        else $error("magnitude subtract borrowed");
  end
endmodule

// File: rtl/fpadd_norm.sv
module fpadd_norm #(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23
) (
  input  logic [FRAC_W+1:0]       raw_sum,
  input  logic                    carry_out,
  input  logic                    exact_zero,
  input  logic [EXP_W-1:0]        big_exp,
  input  logic                    big_sign,
  output logic [$clog2(FRAC_W+2)-1:0] lz_count,
  output logic                    ovf,
  output logic                    unf,
  output logic [EXP_W+FRAC_W:0]   norm_word
);
  localparam int SIG_W = FRAC_W + 1;
  localparam int LZ_W  = $clog2(FRAC_W + 2);
  localparam logic [EXP_W-1:0] EXP_ONES = '1;

  function automatic logic [LZ_W-1:0] count_lz(input logic [SIG_W-1:0] v);
    count_lz = LZ_W'(SIG_W);
    for (int i = 0; i < SIG_W; i++)
      if (v[i]) count_lz = LZ_W'(SIG_W - 1 - i);
  endfunction

  logic [SIG_W-1:0] sig_n;
  logic [EXP_W-1:0] exp_n;

  assign lz_count = count_lz(raw_sum[SIG_W-1:0]);

  always_comb begin
    if (carry_out) begin
      sig_n = raw_sum[SIG_W:1];
      exp_n = big_exp + 1'b1;
    end else begin
      sig_n = raw_sum[SIG_W-1:0] << lz_count;
      exp_n = big_exp - EXP_W'(lz_count);
    end
  end

  assign ovf = carry_out && (big_exp >= EXP_ONES - 1'b1);
  assign unf = !carry_out && ({1'b0, big_exp} <= (EXP_W+1)'(lz_count));

  always_comb begin
    if (exact_zero || unf) norm_word = '0;
    else if (ovf)          norm_word = {big_sign, EXP_ONES, {FRAC_W{1'b0}}};
    else                   norm_word = {big_sign, exp_n, sig_n[FRAC_W-1:0]};
  end

  always_comb begin
    if (!exact_zero)
      assert_hidden_one_R8: assert (sig_n[SIG_W-1])
        else $error("normalized significand lacks its leading one");
  end
endmodule

// File: rtl/fpadd_top.sv
module fpadd_top #(
  parameter int EXP_W  = fpadd_pkg::DEF_EXP_W,
  parameter int FRAC_W = fpadd_pkg::DEF_FRAC_W
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [EXP_W+FRAC_W:0] opnd_a,
  input  logic [EXP_W+FRAC_W:0] opnd_b,
  input  logic                  sub_sel,
  output logic [EXP_W+FRAC_W:0] result
);
  import fpadd_pkg::*;

  localparam int W     = 1 + EXP_W + FRAC_W;
  localparam int SIG_W = FRAC_W + 1;
  localparam int LZ_W  = $clog2(FRAC_W + 2);

  fp_op_e           op;
  logic             b_sign_eff;
  logic             a_zero, b_zero, bypass;
  logic             big_sign, eff_sub;
  logic [EXP_W-1:0] big_exp;
  logic [SIG_W-1:0] big_sig, small_sig_al;
  logic [SIG_W:0]   raw_sum;
  logic             carry_out, exact_zero, ovf, unf;
  logic [LZ_W-1:0]  lz_count;
  logic [W-1:0]     norm_word, next_word, result_q;

  assign op         = fp_op_e'(sub_sel);
  assign b_sign_eff = opnd_b[W-1] ^ (op == OP_SUB);
  assign bypass     = a_zero || b_zero;

  fpadd_align #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_align (
    .a_word(opnd_a), .b_word(opnd_b), .b_sign_eff(b_sign_eff),
    .a_zero(a_zero), .b_zero(b_zero), .big_sign(big_sign),
    .big_exp(big_exp), .big_sig(big_sig), .small_sig_al(small_sig_al),
    .eff_sub(eff_sub)
  );

  fpadd_magadd #(.FRAC_W(FRAC_W)) u_magadd (
    .big_sig(big_sig), .small_sig(small_sig_al), .eff_sub(eff_sub),
    .raw_sum(raw_sum), .carry_out(carry_out), .exact_zero(exact_zero)
  );

  fpadd_norm #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_norm (
    .raw_sum(raw_sum), .carry_out(carry_out), .exact_zero(exact_zero),
    .big_exp(big_exp), .big_sign(big_sign), .lz_count(lz_count),
    .ovf(ovf), .unf(unf), .norm_word(norm_word)
  );

  always_comb begin
    if (a_zero)      next_word = {b_sign_eff, opnd_b[W-2:0]};
    else if (b_zero) next_word = opnd_a;
    else             next_word = norm_word;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) result_q <= '0;
    else        result_q <= next_word;
  end

  assign result = result_q;

  assert_zero_bypass_R4: assert property (@(posedge clk) disable iff (!rst_n)
    a_zero |=> result == {$past(b_sign_eff), $past(opnd_b[W-2:0])});

  assert_exact_zero_pos_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!bypass && exact_zero) |=> result == '0);

  assert_carry_exp_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!bypass && carry_out && !ovf) |=>
      result[W-2:FRAC_W] == EXP_W'($past(big_exp) + 1'b1));

  assert_overflow_inf_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!bypass && ovf) |=> (result[W-2:FRAC_W] == '1 && result[FRAC_W-1:0] == '0));

  assert_sign_larger_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!bypass && !exact_zero && !unf) |=> result[W-1] == $past(big_sign));

  assert_cancel_exp_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!bypass && eff_sub && !exact_zero && !unf) |=>
      result[W-2:FRAC_W] == EXP_W'($past(big_exp) - EXP_W'($past(lz_count))));
endmodule

// File: tb/test_fpadd_top.sv
`timescale 1ns/1ps
module test_fpadd_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [31:0] opnd_a, opnd_b, result;
  logic        sub_sel;
  int          n_checks = 0;
  int          n_fail = 0;

  always #2.5 clk = ~clk;

  fpadd_top i_fpadd_top (
    .clk(clk), .rst_n(rst_n), .opnd_a(opnd_a), .opnd_b(opnd_b),
    .sub_sel(sub_sel), .result(result)
  );

  typedef struct packed {
    logic [31:0] a;
    logic [31:0] b;
    logic        op;
    logic [31:0] want;
    logic [3:0]  req;
  } vec_t;

  localparam int NVEC = 16;
  localparam vec_t VECS [NVEC] = '{
    '{32'h3F800000, 32'h3F800000, 1'b0, 32'h40000000, 4'd6 },  // R6 1+1
    '{32'h3F800000, 32'h3F800000, 1'b1, 32'h00000000, 4'd9 },  // R9 1-1 -> +0
    '{32'h40000000, 32'h3F800000, 1'b0, 32'h40400000, 4'd5 },  // R5 2+1
    '{32'h3F800000, 32'h40000000, 1'b1, 32'hBF800000, 4'd3 },  // R3 1-2
    '{32'h00000000, 32'h3FC00000, 1'b1, 32'hBFC00000, 4'd4 },  // R4 0-1.5
    '{32'h40A00000, 32'h00000000, 1'b0, 32'h40A00000, 4'd4 },  // R4 5+0
    '{32'hC0400000, 32'h3F800000, 1'b0, 32'hC0000000, 4'd7 },  // R7 -3+1
    '{32'h3F800000, 32'h30800000, 1'b0, 32'h3F800000, 4'd5 },  // R5 gap 30
    '{32'h7F7FFFFF, 32'h7F7FFFFF, 1'b0, 32'h7F800000, 4'd10},  // R10 max+max
    '{32'h00C00000, 32'h00800000, 1'b1, 32'h00000000, 4'd11},  // R11 flush
    '{32'h3FC00000, 32'h3F800000, 1'b0, 32'h40200000, 4'd6 },  // R6 1.5+1
    '{32'h3F800001, 32'h3F800000, 1'b0, 32'h40000000, 4'd6 },  // R6 truncating shift
    '{32'h80000000, 32'h3F800000, 1'b0, 32'h3F800000, 4'd4 },  // R4 -0+1
    '{32'h3F800001, 32'h3F800000, 1'b1, 32'h34000000, 4'd8 },  // R8 one ulp
    '{32'h3F800000, 32'hBFC00000, 1'b0, 32'hBF000000, 4'd7 },  // R7 1+(-1.5)
    '{32'h41200000, 32'h40400000, 1'b1, 32'h40E00000, 4'd1 }   // R1 10-3
  };

  // reference restated from the requirements with plain integers
  function automatic logic [31:0] ref_fp(input logic [31:0] a, input logic [31:0] b,
                                          input logic op);
    logic sb, sl;
    int ea, eb, el, es, e;
    longint ma, mb, ml, ms, s;
    sb = b[31] ^ op;
    ea = int'(a[30:23]);
    eb = int'(b[30:23]);
    if (ea == 0) return {sb, b[30:0]};
    if (eb == 0) return a;
    ma = longint'({1'b1, a[22:0]});
    mb = longint'({1'b1, b[22:0]});
    if (a[30:0] >= b[30:0]) begin el = ea; es = eb; ml = ma; ms = mb; sl = a[31]; end
    else begin el = eb; es = ea; ml = mb; ms = ma; sl = sb; end
    ms = (el - es > 40) ? 0 : (ms >> (el - es));
    e = el;
    if (a[31] == sb) begin
      s = ml + ms;
      if (s >= 64'd16777216) begin s = s >> 1; e = e + 1; end
      if (e >= 255) return {sl, 8'hFF, 23'd0};
    end else begin
      s = ml - ms;
      if (s == 0) return 32'd0;
      while (s < 64'd8388608) begin s = s << 1; e = e - 1; end
      if (e <= 0) return 32'd0;
    end
    return {sl, 8'(e), s[22:0]};
  endfunction

  task automatic check(input logic [31:0] want, input string tag);
    n_checks++;
    if (result !== want) begin
      n_fail++;
      $display("FAIL %s: result=%08h expected=%08h", tag, result, want);
    end
  endtask

  task automatic apply(input logic [31:0] a, input logic [31:0] b, input logic op);
    @(negedge clk);
    opnd_a = a; opnd_b = b; sub_sel = op;
    @(negedge clk);
  endtask

  initial begin
    #200000;
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: result=%08h expected=completion", result);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] seed;
    rst_n = 1'b0; opnd_a = 32'h40400000; opnd_b = 32'h3F800000; sub_sel = 1'b0;
    repeat (3) @(negedge clk);
    check(32'h0, "R2 reset holds zero");
    rst_n = 1'b1;
    @(negedge clk);
    check(32'h40800000, "R2 first result after reset");

    for (int i = 0; i < NVEC; i++) begin
      apply(VECS[i].a, VECS[i].b, VECS[i].op);
      check(VECS[i].want, $sformatf("R%0d table entry %0d", VECS[i].req, i));
    end

    // R2: new operands do not reach the output before the next edge
    apply(32'h3F800000, 32'h3F800000, 1'b0);
    @(negedge clk);
    opnd_a = 32'h40000000; opnd_b = 32'h40000000;
    #1 check(32'h40000000, "R2 output stable before edge");
    @(negedge clk);
    check(32'h40800000, "R2 result one edge later");

    // R3: same operands, the select alone flips add to subtract
    apply(32'h40400000, 32'h3F800000, 1'b1);
    check(32'h40000000, "R3 3-1");

    // R10: largest finite minus negative largest also saturates
    apply(32'h7F7FFFFF, 32'hFF7FFFFF, 1'b1);
    check(32'h7F800000, "R10 max-(-max)");

    // R8/R11: exponent sweep with close magnitudes, checked against the model
    seed = 32'h1234_5678;
    for (int i = 0; i < 60; i++) begin
      logic [31:0] x, y;
      logic        o;
      seed = seed ^ (seed << 13); seed = seed ^ (seed >> 17); seed = seed ^ (seed << 5);
      x = {seed[31], (i < 30) ? 8'd1 + 8'(seed[2:0]) : 8'd124 + 8'(seed[4:3]), seed[22:0]};
      seed = seed ^ (seed << 13); seed = seed ^ (seed >> 17); seed = seed ^ (seed << 5);
      y = {seed[31], x[30:23] + 8'(seed[0]), x[22:8], seed[7:0]};
      o = seed[9];
      apply(x, y, o);
      check(ref_fp(x, y, o), $sformatf("R8 R11 sweep %0d", i));
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end
endmodule